// File: doc/BRIEF.md
# Shared Timer with Per-Processor Comparators

This block keeps one 64-bit up-counter that all processors share, and a set of comparators, one bank for each processor. When the shared timer runs, the counter advances once every (prescale + 1) clock cycles. Each bank holds a 64-bit match value and an interval. It also holds its own enable bits for matching, for interrupts and for automatic re-arming, plus a sticky match flag that drives that processor's interrupt line. A bank in periodic mode moves its match value forward by whole intervals each time it fires, so the line can be used as a regular tick.

Every processor reaches the block through one 32-bit register window. A processor-index input goes with each request and picks the bank. Shared state (run bit, prescale, counter) is visible through every window. The counter can only be loaded while the timer is stopped. Requests use a valid/ready handshake on the request side. `req_ready` is always high, so a request is taken in the cycle it is presented and there is never back-pressure. Read data comes back on `rsp_valid` exactly one cycle later. The response side has no ready and must be consumed when it appears.

Top module: `gtmr_top`

## Requirements
- R1: The counter is read and written as a low word at offset 0x00 and a high word at 0x04. The match value uses 0x10 (low) and 0x14 (high), and the interval uses 0x18. Every written value reads back unchanged, and a carry from the low word goes into the high word.
- R2: Control offset 0x08 holds the shared run bit at bit 0 and an 8-bit prescale at bits 15:8. While running, the counter goes up by one on every (prescale + 1)-th clock edge counted from the edge that set the run bit. The prescale phase restarts whenever the timer is stopped.
- R3: A counter write at 0x00 or 0x04 has no effect while the run bit is set.
- R4: A bank's match fires only when the shared run bit and that bank's match enable (control bit 1) are both set and the counter is greater than or equal to the bank's match value.
- R5: A match sets the bank's flag (status offset 0x0C, bit 0), and the flag stays set. The bank's `irq` bit is high exactly when the flag is set and the bank's interrupt enable (control bit 2) is set.
- R6: A status write clears the flag when data bit 0 is 1 and leaves it unchanged when bit 0 is 0. A match in the same cycle takes priority over the clear.
- R7: When a bank fires with periodic mode (control bit 3) set and a nonzero interval, its match value goes up by the smallest whole multiple of the interval that puts it above the counter. This includes an exact hit and a value far behind. With a zero interval the match value stays where it is.
- R8: Bits 3:1 of control are banked for the requesting processor. Run and prescale are shared. A control read returns the shared bits ORed with the requester's own bits, and a control write updates both parts.
- R9: After reset the counter, control, flags, match values, intervals and all `irq` bits are zero.
- R10: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 return zero, and writes to them change nothing.
- R11: A request whose processor index is at or above NUM_CPU reads zero, and its writes are dropped, including writes to the counter.
- R12: `req_ready` is always high. Every read gives one `rsp_valid` pulse on the following cycle, and writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset in the register window |
| req_cpu | input | CPU_ID_W | Index of the requesting processor |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| irq | output | NUM_CPU | Per-processor interrupt lines |

## Verification
The counter is run under two prescale settings. A small prescale checks the step rate and the carry across the word boundary. A large prescale holds the count still, which lets a refused load while running be told apart from a counter that is just moving. Matching is tried with four match-value patterns: above the count, exactly equal, well behind, and behind with a zero interval. These separate a single interval step from the multiple-step catch-up and from the no-advance case. The shared and banked control bits are written from different processor indices, and an index beyond the configured count is used, so that a mixed-up bank selection shows up as a wrong read value or a wrong `irq` bit.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int HALF_W = 32;
  localparam int ADDR_W = 5;
  localparam int PSC_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CTL    = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CMP_LO = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_CMP_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_INC    = 5'h18;

  localparam int BIT_RUN     = 0;
  localparam int BIT_MATCH   = 1;
  localparam int BIT_IRQ     = 2;
  localparam int BIT_PERIOD  = 3;
  localparam int PSC_LSB     = 8;

  typedef struct packed {
    logic match_en;
    logic irq_en;
    logic period_en;
  } bank_ctl_t;
endpackage

// File: rtl/gtmr_count.sv
module gtmr_count #(
  parameter int HALF_W = 32,
  parameter int PSC_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PSC_W-1:0]    psc,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] count
);
  localparam int CNT_W = 2 * HALF_W;

  logic [PSC_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      count <= '0;
    end else if (run) begin
      if (phase == psc) begin
        phase <= '0;
        count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
      end else begin
        phase <= phase + {{(PSC_W-1){1'b0}}, 1'b1};
      end
    end else begin
      phase <= '0;
      if (wr_lo) count[HALF_W-1:0]     <= wdata;
      if (wr_hi) count[CNT_W-1:HALF_W] <= wdata;
    end
  end
endmodule

// File: rtl/gtmr_bank.sv
module gtmr_bank
  import gtmr_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [2*HALF_W-1:0] count,
  input  logic                ctl_wr,
  input  bank_ctl_t           ctl_in,
  input  logic                stat_clr,
  input  logic                cmp_lo_wr,
  input  logic                cmp_hi_wr,
  input  logic                inc_wr,
  input  logic [HALF_W-1:0]   wdata,
  output bank_ctl_t           ctl,
  output logic                flag,
  output logic [2*HALF_W-1:0] match_val,
  output logic [HALF_W-1:0]   interval,
  output logic                fire,
  output logic                fire_adv,
  output logic                irq
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] inc_ext, gap, divisor, steps, advanced;

  assign fire     = run && ctl.match_en && (count >= match_val);
  assign fire_adv = fire && ctl.period_en && (interval != '0);
  assign inc_ext  = {{HALF_W{1'b0}}, interval};

  // Catch-up: smallest multiple of the interval that lands above the count
  always_comb begin
    gap      = count - match_val;
    divisor  = (interval == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : inc_ext;
    steps    = (gap / divisor) + {{(CNT_W-1){1'b0}}, 1'b1};
    advanced = match_val + steps * inc_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl       <= '0;
      flag      <= 1'b0;
      match_val <= '0;
      interval  <= '0;
    end else begin
      if (ctl_wr) ctl <= ctl_in;
      if (inc_wr) interval <= wdata;
      if (fire)          flag <= 1'b1;
      else if (stat_clr) flag <= 1'b0;
      if (cmp_lo_wr || cmp_hi_wr) begin
        if (cmp_lo_wr) match_val[HALF_W-1:0]     <= wdata;
        if (cmp_hi_wr) match_val[CNT_W-1:HALF_W] <= wdata;
      end else if (fire_adv) begin
        match_val <= advanced;
      end
    end
  end

  assign irq = flag && ctl.irq_en;
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int NUM_CPU  = 3,
  parameter int CPU_ID_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [CPU_ID_W-1:0] req_cpu,
  input  logic [HALF_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [HALF_W-1:0]   rsp_data,
  output logic [NUM_CPU-1:0]  irq
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [CPU_ID_W:0] NCPU_V = (CPU_ID_W+1)'(NUM_CPU);

  logic                cpu_ok, wr_en, cnt_wr_req;
  logic                run;
  logic [PSC_W-1:0]    psc;
  logic [CNT_W-1:0]    count;
  logic [NUM_CPU-1:0]  sel, b_flag, b_fire, b_adv, b_cmp_wr, b_clr, b_match_en;
  logic [NUM_CPU-1:0][CNT_W-1:0]  b_cmp;
  logic [NUM_CPU-1:0][HALF_W-1:0] b_inc;
  bank_ctl_t           b_ctl [NUM_CPU];
  bank_ctl_t           ctl_in;

  assign req_ready  = 1'b1;
  assign cpu_ok     = ({1'b0, req_cpu} < NCPU_V);
  assign wr_en      = req_valid && req_write && cpu_ok;
  assign cnt_wr_req = wr_en && (req_addr == OFF_CNT_LO || req_addr == OFF_CNT_HI);

  assign ctl_in.match_en  = req_wdata[BIT_MATCH];
  assign ctl_in.irq_en    = req_wdata[BIT_IRQ];
  assign ctl_in.period_en = req_wdata[BIT_PERIOD];

  // Shared control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      psc <= '0;
    end else if (wr_en && req_addr == OFF_CTL) begin
      run <= req_wdata[BIT_RUN];
      psc <= req_wdata[PSC_LSB +: PSC_W];
    end
  end

  gtmr_count #(.HALF_W(HALF_W), .PSC_W(PSC_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .psc   (psc),
    .wr_lo (wr_en && req_addr == OFF_CNT_LO),
    .wr_hi (wr_en && req_addr == OFF_CNT_HI),
    .wdata (req_wdata),
    .count (count)
  );

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_bank
    logic bw;
    assign sel[i]        = cpu_ok && (req_cpu == CPU_ID_W'(i));
    assign bw            = wr_en && sel[i];
    assign b_cmp_wr[i]   = bw && (req_addr == OFF_CMP_LO || req_addr == OFF_CMP_HI);
    assign b_clr[i]      = bw && (req_addr == OFF_STAT) && req_wdata[0];
    assign b_match_en[i] = b_ctl[i].match_en;

    gtmr_bank #(.HALF_W(HALF_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .count     (count),
      .ctl_wr    (bw && req_addr == OFF_CTL),
      .ctl_in    (ctl_in),
      .stat_clr  (b_clr[i]),
      .cmp_lo_wr (bw && req_addr == OFF_CMP_LO),
      .cmp_hi_wr (bw && req_addr == OFF_CMP_HI),
      .inc_wr    (bw && req_addr == OFF_INC),
      .wdata     (req_wdata),
      .ctl       (b_ctl[i]),
      .flag      (b_flag[i]),
      .match_val (b_cmp[i]),
      .interval  (b_inc[i]),
      .fire      (b_fire[i]),
      .fire_adv  (b_adv[i]),
      .irq       (irq[i])
    );
  end

  // Read path
  bank_ctl_t         r_ctl;
  logic              r_flag;
  logic [CNT_W-1:0]  r_cmp;
  logic [HALF_W-1:0] r_inc, r_word;

  always_comb begin
    r_ctl  = '0;
    r_flag = 1'b0;
    r_cmp  = '0;
    r_inc  = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (sel[i]) begin
        r_ctl  = b_ctl[i];
        r_flag = b_flag[i];
        r_cmp  = b_cmp[i];
        r_inc  = b_inc[i];
      end
    end
    r_word = '0;
    case (req_addr)
      OFF_CNT_LO: r_word = count[HALF_W-1:0];
      OFF_CNT_HI: r_word = count[CNT_W-1:HALF_W];
      OFF_CTL: begin
        r_word[BIT_RUN]              = run;
        r_word[BIT_MATCH]            = r_ctl.match_en;
        r_word[BIT_IRQ]              = r_ctl.irq_en;
        r_word[BIT_PERIOD]           = r_ctl.period_en;
        r_word[PSC_LSB +: PSC_W]     = psc;
      end
      OFF_STAT:   r_word[0] = r_flag;
      OFF_CMP_LO: r_word = r_cmp[HALF_W-1:0];
      OFF_CMP_HI: r_word = r_cmp[CNT_W-1:HALF_W];
      OFF_INC:    r_word = r_inc;
      default:    r_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_data <= cpu_ok ? r_word : '0;
    end
  end
endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker #(
  parameter int NUM_CPU = 3,
  parameter int CNT_W   = 64
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic                           req_write,
  input logic                           rsp_valid,
  input logic                           run,
  input logic                           cnt_wr_req,
  input logic [CNT_W-1:0]               count,
  input logic [NUM_CPU-1:0]             b_flag,
  input logic [NUM_CPU-1:0]             b_adv,
  input logic [NUM_CPU-1:0]             b_cmp_wr,
  input logic [NUM_CPU-1:0]             b_clr,
  input logic [NUM_CPU-1:0]             b_match_en,
  input logic [NUM_CPU-1:0][CNT_W-1:0]  b_cmp,
  input logic [NUM_CPU-1:0]             irq
);
  // R2: the count moves by at most one step per cycle while running
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (count == $past(count) || count == $past(count) + 1'b1));

  // R3: while running, a load attempt cannot move the count by more than one step
  assert_cnt_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_wr_req) |=> (count == $past(count) || count == $past(count) + 1'b1));

  // R1: a stopped counter without a load keeps its value
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr_req) |=> $stable(count));

  // R12: one response per read, on the next cycle
  assert_rsp_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_rsp_none_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_chk
    // R4: a flag only rises when running with matching enabled
    assert_flag_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_flag[i]) |-> $past(run && b_match_en[i]));

    // R6: a flag only falls after a clearing write
    assert_flag_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(b_flag[i]) |-> $past(b_clr[i]));

    // R5: interrupt line needs the flag
    assert_irq_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> b_flag[i]);

    // R7: periodic advance puts the match value above the count
    assert_adv_ahead_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (b_adv[i] && !b_cmp_wr[i]) |=> (b_cmp[i] > $past(count)));
  end
endmodule

bind gtmr_top gtmr_checker #(.NUM_CPU(NUM_CPU), .CNT_W(2*gtmr_pkg::HALF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .run        (run),
  .cnt_wr_req (cnt_wr_req),
  .count      (count),
  .b_flag     (b_flag),
  .b_adv      (b_adv),
  .b_cmp_wr   (b_cmp_wr),
  .b_clr      (b_clr),
  .b_match_en (b_match_en),
  .b_cmp      (b_cmp),
  .irq        (irq)
);

// File: tb/gtmr_top_tb.sv
module gtmr_top_tb;
  localparam int NUM_CPU  = 3;
  localparam int CPU_ID_W = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic                req_write = 1'b0;
  logic [4:0]          req_addr = '0;
  logic [CPU_ID_W-1:0] req_cpu = '0;
  logic [31:0]         req_wdata = '0;
  logic                rsp_valid;
  logic [31:0]         rsp_data;
  logic [NUM_CPU-1:0]  irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  gtmr_top #(.NUM_CPU(NUM_CPU), .CPU_ID_W(CPU_ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_cpu(req_cpu),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
  );

  task automatic wr(input logic [CPU_ID_W-1:0] cpu, input logic [4:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_cpu = cpu; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [CPU_ID_W-1:0] cpu, input logic [4:0] a,
                    input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_cpu = cpu; req_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R12: unexpected response got %h expected none", rsp_data);
      end else begin
        chk(rsp_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk({29'b0, irq}, 32'h0, "R9 irq after reset");
    chk({31'b0, req_ready}, 32'h1, "R12 ready high");
    rd(0, 5'h00, 32'h0, "R9 count lo");
    rd(0, 5'h04, 32'h0, "R9 count hi");
    rd(0, 5'h08, 32'h0, "R9 control");
    rd(0, 5'h0C, 32'h0, "R9 status");
    rd(0, 5'h10, 32'h0, "R9 match lo");
    rd(0, 5'h14, 32'h0, "R9 match hi");
    rd(0, 5'h18, 32'h0, "R9 interval");

    // R1 counter load and readback
    wr(0, 5'h00, 32'hFFFF_FFFE);
    chk({31'b0, rsp_valid}, 32'h0, "R12 no response to write");
    wr(0, 5'h04, 32'h1);
    rd(0, 5'h00, 32'hFFFF_FFFE, "R1 count lo");
    rd(0, 5'h04, 32'h1, "R1 count hi");

    // R2 prescale 3 for 40 edges -> +10 with carry
    wr(0, 5'h08, 32'h301);
    repeat (39) @(negedge clk);
    wr(0, 5'h08, 32'h300);
    rd(0, 5'h00, 32'h8, "R2 count lo after run");
    rd(0, 5'h04, 32'h2, "R2 count hi carry");
    rd(0, 5'h08, 32'h300, "R2 control readback");

    // R3 loads refused while running (prescale 255 keeps count still)
    wr(0, 5'h08, 32'hFF01);
    wr(0, 5'h00, 32'h1234);
    wr(0, 5'h04, 32'h55);
    wr(0, 5'h08, 32'h0);
    rd(0, 5'h00, 32'h8, "R3 lo load ignored");
    rd(0, 5'h04, 32'h2, "R3 hi load ignored");

    // R8 banked and shared control
    wr(0, 5'h08, 32'h6);
    wr(1, 5'h08, 32'h8);
    rd(0, 5'h08, 32'h6, "R8 cpu0 banked");
    rd(1, 5'h08, 32'h8, "R8 cpu1 banked");
    wr(2, 5'h08, 32'h300);
    rd(0, 5'h08, 32'h306, "R8 shared prescale seen by cpu0");
    rd(2, 5'h08, 32'h300, "R8 cpu2 banked empty");

    // R4 no match while stopped even though match value 0 <= count
    repeat (5) @(negedge clk);
    rd(0, 5'h0C, 32'h0, "R4 no match when stopped");
    chk({29'b0, irq}, 32'h0, "R4 irq idle when stopped");

    // R11 index beyond NUM_CPU
    wr(3, 5'h08, 32'h1);
    rd(0, 5'h08, 32'h306, "R11 control write dropped");
    rd(3, 5'h08, 32'h0, "R11 control read zero");
    rd(3, 5'h00, 32'h0, "R11 count read zero");
    wr(3, 5'h00, 32'hAAAA);
    rd(0, 5'h00, 32'h8, "R11 count write dropped");

    // R10 unmapped offset
    wr(0, 5'h1C, 32'hFFFF_FFFF);
    rd(0, 5'h1C, 32'h0, "R10 unmapped read");
    rd(0, 5'h08, 32'h306, "R10 unmapped write no effect");

    // R4/R5 match event on cpu0
    wr(0, 5'h10, 32'h10);
    wr(0, 5'h14, 32'h2);
    wr(0, 5'h08, 32'h7);
    rd(0, 5'h0C, 32'h0, "R4 flag clear before match");
    repeat (20) @(negedge clk);
    chk({31'b0, irq[0]}, 32'h1, "R5 irq0 after match");
    rd(0, 5'h0C, 32'h1, "R4 flag after match");
    rd(1, 5'h0C, 32'h0, "R4 cpu1 match disabled");
    chk({31'b0, irq[1]}, 32'h0, "R5 irq1 quiet");

    // R5 sticky after stopping
    wr(0, 5'h08, 32'h6);
    repeat (5) @(negedge clk);
    rd(0, 5'h0C, 32'h1, "R5 flag sticky");
    chk({31'b0, irq[0]}, 32'h1, "R5 irq0 held");

    // R6 write-one-to-clear
    wr(0, 5'h0C, 32'hFFFF_FFFE);
    rd(0, 5'h0C, 32'h1, "R6 zero bit keeps flag");
    wr(0, 5'h0C, 32'h1);
    rd(0, 5'h0C, 32'h0, "R6 one bit clears flag");
    chk({31'b0, irq[0]}, 32'h0, "R6 irq0 dropped");

    // R7 periodic catch-up from behind
    wr(0, 5'h00, 32'h100);
    wr(0, 5'h04, 32'h0);
    wr(1, 5'h10, 32'hF4);
    wr(1, 5'h18, 32'h5);
    rd(1, 5'h18, 32'h5, "R1 interval readback");
    wr(1, 5'h08, 32'hFF0B);
    wr(1, 5'h08, 32'h0A);
    rd(1, 5'h10, 32'h103, "R7 catch-up match lo");
    rd(1, 5'h14, 32'h0, "R7 catch-up match hi");
    rd(1, 5'h0C, 32'h1, "R7 flag set on advance");

    // R7 exact hit
    wr(1, 5'h0C, 32'h1);
    wr(1, 5'h10, 32'h100);
    wr(1, 5'h08, 32'hFF0B);
    wr(1, 5'h08, 32'h0A);
    rd(1, 5'h10, 32'h105, "R7 exact hit advance");

    // R7 zero interval keeps match value
    wr(2, 5'h10, 32'h80);
    wr(2, 5'h08, 32'hFF0B);
    wr(2, 5'h08, 32'h0A);
    rd(2, 5'h10, 32'h80, "R7 zero interval no advance");
    rd(2, 5'h0C, 32'h1, "R7 zero interval still flags");

    // R5 interrupt enable gating
    chk({31'b0, irq[1]}, 32'h0, "R5 irq1 gated off");
    wr(1, 5'h04 + 5'h04, 32'h4);
    chk({31'b0, irq[1]}, 32'h1, "R5 irq1 enabled");
    chk({31'b0, irq[2]}, 32'h0, "R5 irq2 gated off");
    rd(0, 5'h00, 32'h100, "R3 count unchanged by slow runs");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 32'h0, "R12 all reads answered");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end
endmodule